// File: doc/BRIEF.md
# UART Channel Ready and Interrupt Flags

This block produces the three status outputs of one serial channel whose transmit and receive buffers are each up to 16 bytes deep. It has an active-low receive-ready line and an active-low transmit-ready line, which an external DMA engine watches. It also has an active-high interrupt line. The block keeps its own occupancy counters for both buffers, so it can be tested on its own. It counts byte strobes from the receive and transmit data paths (receive write, host read, host write, shifter take) and turns the counts into the three outputs.

The rules for the ready lines depend on the operating mode. With buffering off, each direction holds a single byte. With buffering on and DMA off, the lines report empty or non-empty. With buffering on and DMA on, the transmit line reports free space. In that mode the receive line has hysteresis: it falls at the programmed trigger level, or on a receive timeout, and rises again only when the buffer is drained. The interrupt line combines transmit-empty with receive data, or with the receive trigger level or a pending timeout.

Top module: `uart_ready_flags`

## Requirements
- R1: While `rst` is high, `rx_rdy_n` is 1, `tx_rdy_n` is 0 and `irq` is 0.
- R2: With `fifo_en`=0, each direction holds at most one byte. `rx_rdy_n` is 0 exactly when a received byte is held. `tx_rdy_n` is 1 exactly when the transmit holding byte is occupied. `dma_mode` has no effect in this mode.
- R3: With `fifo_en`=1 and `dma_mode`=0, `rx_rdy_n` is 0 while the receive count is at least 1. `tx_rdy_n` is 0 only while the transmit count is 0.
- R4: With `fifo_en`=1 and `dma_mode`=1, `rx_rdy_n` falls when the receive count reaches the trigger level or the timeout flag is set. Once low, it stays low until the receive count is 0.
- R5: With `fifo_en`=1 and `dma_mode`=1, `tx_rdy_n` is 0 while the transmit count is below DEPTH (16) and 1 when the count equals DEPTH.
- R6: With `fifo_en`=0, `irq` is 1 when the transmit holding byte is empty or a received byte is held, and 0 otherwise.
- R7: With `fifo_en`=1, `irq` is 1 when any of these holds: the transmit count is 0, the receive count is at or above the trigger level, or the timeout flag is set. Otherwise it is 0.
- R8: The trigger level is selected by `trig_sel`: 2'b00 gives 1 byte, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R9: A one-cycle `rx_timeout` pulse sets an internal timeout flag. The flag clears in any cycle where the receive count is 0.
- R10: A push into a full buffer is dropped, and a pop from an empty buffer is dropped. If a push and a pop arrive together on a full buffer, only the pop takes effect.
- R11: Any change of `fifo_en` empties both counters at the next clock edge.
- R12: A counter changes on the edge that samples its strobe. The outputs follow on the next edge, which is two edges after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | 1 = 16-byte buffering, 0 = single-byte holding |
| dma_mode | input | 1 | 1 = DMA signalling on the ready lines (only with fifo_en=1) |
| trig_sel | input | 2 | Receive trigger level select |
| rx_push | input | 1 | Receive path wrote one byte |
| rx_pop | input | 1 | Host read one received byte |
| tx_push | input | 1 | Host wrote one byte to transmit |
| tx_pop | input | 1 | Transmit shifter took one byte |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| rx_rdy_n | output | 1 | Receive ready, active low, registered |
| tx_rdy_n | output | 1 | Transmit ready, active low, registered |
| irq | output | 1 | Channel interrupt, active high, registered |

## Verification
The receive path is driven through three kinds of sequence.
- Fills that stop one byte below the trigger level and fills that end exactly on it. These separate a trigger comparison from a simple non-empty test.
- In DMA mode, drains that stop at one byte. These show the hysteresis, which a level-following output would not.
- A lone timeout pulse with a near-empty buffer. This separates the timeout path from the level path.

The transmit path is filled to 15 and then to 16 bytes, then pushed while full, and given a push and pop in the same cycle. Together these expose an off-by-one full test and a wrongly accepted push. Toggling `fifo_en` with data held shows the flush. Running the same strobes with buffering off and DMA requested shows that the single-byte rules win.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  typedef enum logic [1:0] {
    MODE_CHAR = 2'd0,
    MODE_FIFO = 2'd1,
    MODE_DMA  = 2'd2
  } flag_mode_e;

  // R8: trigger select -> byte count, scaled from the buffer depth
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count
);

  logic push_ok, pop_ok;

  // R10: a full buffer rejects pushes, an empty one rejects pops
  assign push_ok = push && (count < cap);
  assign pop_ok  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      count <= '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (count == cap && push && !pop && !flush) |=> (count == $past(count))); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0)); // R11

endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic rx_empty,
  output logic flag
);

  // R9: sticky until the receive buffer is drained; empty wins over a pulse
  always_ff @(posedge clk) begin
    if (rst || rx_empty) flag <= 1'b0;
    else if (pulse)      flag <= 1'b1;
  end

  AST_TMO_CLEARS_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> !flag); // R9
  AST_TMO_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    (pulse && !rx_empty) |=> flag); // R9

endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import uart_flag_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          dma_mode,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic          tmo,
  output logic          rx_rdy_n,
  output logic          tx_rdy_n,
  output logic          irq
);

  flag_mode_e    mode;
  logic [CW-1:0] trig_cnt;
  logic          rx_empty, rx_hit, tx_empty, tx_full;
  logic          rx_n_d, tx_n_d, irq_d;

  // R2: with buffering off the DMA bit is not looked at
  assign mode     = !fifo_en ? MODE_CHAR : (dma_mode ? MODE_DMA : MODE_FIFO);
  assign trig_cnt = CW'(trig_level(trig_sel, DEPTH));   // R8
  assign rx_empty = (rx_cnt == '0);
  assign rx_hit   = (rx_cnt >= trig_cnt);
  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));

  always_comb begin
    rx_n_d = 1'b1;
    tx_n_d = 1'b0;
    irq_d  = 1'b0;
    case (mode)
      MODE_CHAR: begin                    // R2, R6
        rx_n_d = rx_empty;
        tx_n_d = !tx_empty;
        irq_d  = tx_empty || !rx_empty;
      end
      MODE_FIFO: begin                    // R3, R7
        rx_n_d = rx_empty;
        tx_n_d = !tx_empty;
        irq_d  = tx_empty || rx_hit || tmo;
      end
      MODE_DMA: begin                     // R4, R5, R7
        rx_n_d = rx_empty ? 1'b1 : (rx_rdy_n && !(rx_hit || tmo));
        tx_n_d = tx_full;
        irq_d  = tx_empty || rx_hit || tmo;
      end
      default: begin
        rx_n_d = 1'b1;
        tx_n_d = 1'b0;
        irq_d  = 1'b0;
      end
    endcase
  end

  // R1, R12: registered outputs, idle values under reset
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_rdy_n <= 1'b1;
      tx_rdy_n <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rx_rdy_n <= rx_n_d;
      tx_rdy_n <= tx_n_d;
      irq      <= irq_d;
    end
  end

  AST_RX_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    rx_empty |=> rx_rdy_n); // R3
  AST_DMA_RX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode && !rx_rdy_n && !rx_empty) |=> !rx_rdy_n); // R4
  AST_DMA_TX_FULL: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && dma_mode && tx_full) |=> tx_rdy_n); // R5
  AST_CHAR_TX_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !tx_empty) |=> tx_rdy_n); // R2
  AST_CHAR_RX_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !rx_empty) |=> irq); // R6
  AST_TMO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && tmo) |=> irq); // R7

endmodule

// File: rtl/uart_ready_flags.sv
module uart_ready_flags
  import uart_flag_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_en,
  input  logic       dma_mode,
  input  logic [1:0] trig_sel,
  input  logic       rx_push,
  input  logic       rx_pop,
  input  logic       tx_push,
  input  logic       tx_pop,
  input  logic       rx_timeout,
  output logic       rx_rdy_n,
  output logic       tx_rdy_n,
  output logic       irq
);

  localparam int CW  = $clog2(DEPTH + 1);
  localparam int NCH = 2;   // index 0 = receive, 1 = transmit

  logic          fifo_en_q, flush;
  logic [CW-1:0] cap;
  logic          push_v [NCH];
  logic          pop_v  [NCH];
  logic [CW-1:0] cnt_v  [NCH];
  logic          tmo;

  // R11: any change of the buffering mode empties both directions
  always_ff @(posedge clk) begin
    if (rst) fifo_en_q <= 1'b0;
    else     fifo_en_q <= fifo_en;
  end
  assign flush = fifo_en ^ fifo_en_q;

  // R2: single holding byte when buffering is off
  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  assign push_v[0] = rx_push;
  assign pop_v[0]  = rx_pop;
  assign push_v[1] = tx_push;
  assign pop_v[1]  = tx_pop;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    occ_counter #(.DEPTH(DEPTH)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .flush (flush),
      .cap   (cap),
      .push  (push_v[c]),
      .pop   (pop_v[c]),
      .count (cnt_v[c])
    );
  end

  tmo_flag u_tmo (
    .clk      (clk),
    .rst      (rst),
    .pulse    (rx_timeout),
    .rx_empty (cnt_v[0] == '0),
    .flag     (tmo)
  );

  flag_gen #(.DEPTH(DEPTH)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .trig_sel (trig_sel),
    .rx_cnt   (cnt_v[0]),
    .tx_cnt   (cnt_v[1]),
    .tmo      (tmo),
    .rx_rdy_n (rx_rdy_n),
    .tx_rdy_n (tx_rdy_n),
    .irq      (irq)
  );

endmodule

// File: tb/uart_ready_flags_tb.sv
`timescale 1ns/1ps
module uart_ready_flags_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0, dma_mode = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0, rx_timeout = 1'b0;
  logic rx_rdy_n, tx_rdy_n, irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_ready_flags u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_sel(trig_sel),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_timeout(rx_timeout), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    step(2);
  endtask

  task automatic push_rx(input int n);
    for (int i = 0; i < n; i++) begin rx_push = 1'b1; step(1); rx_push = 1'b0; end
    settle();
  endtask

  task automatic pop_rx(input int n);
    for (int i = 0; i < n; i++) begin rx_pop = 1'b1; step(1); rx_pop = 1'b0; end
    settle();
  endtask

  task automatic push_tx(input int n);
    for (int i = 0; i < n; i++) begin tx_push = 1'b1; step(1); tx_push = 1'b0; end
    settle();
  endtask

  task automatic pop_tx(input int n);
    for (int i = 0; i < n; i++) begin tx_pop = 1'b1; step(1); tx_pop = 1'b0; end
    settle();
  endtask

  task automatic t_reset();
    step(3);
    chk("R1", "rx_rdy_n in reset", rx_rdy_n, 1'b1);
    chk("R1", "tx_rdy_n in reset", tx_rdy_n, 1'b0);
    chk("R1", "irq in reset", irq, 1'b0);
    rst = 1'b0;
    settle();
  endtask

  task automatic t_char_mode();
    chk("R6", "irq idle, holding empty", irq, 1'b1);
    push_rx(1);
    chk("R2", "rx_rdy_n with byte held", rx_rdy_n, 1'b0);
    push_rx(1);                      // second byte dropped, capacity one
    pop_rx(1);
    chk("R2", "rx_rdy_n after single pop", rx_rdy_n, 1'b1);
    push_tx(1);
    chk("R2", "tx_rdy_n holding full", tx_rdy_n, 1'b1);
    chk("R6", "irq tx full rx empty", irq, 1'b0);
    pop_tx(1);
    chk("R2", "tx_rdy_n holding empty", tx_rdy_n, 1'b0);
  endtask

  task automatic t_fifo_mode();
    fifo_en = 1'b1;
    settle();
    rx_push = 1'b1; step(1); rx_push = 1'b0;
    chk("R12", "rx_rdy_n one edge after strobe", rx_rdy_n, 1'b1);
    step(1);
    chk("R12", "rx_rdy_n two edges after strobe", rx_rdy_n, 1'b0);
    push_rx(2);
    pop_rx(2);
    chk("R3", "rx_rdy_n with one byte", rx_rdy_n, 1'b0);
    pop_rx(1);
    chk("R3", "rx_rdy_n empty", rx_rdy_n, 1'b1);
    push_tx(1);
    chk("R3", "tx_rdy_n one byte", tx_rdy_n, 1'b1);
    chk("R7", "irq tx busy rx empty", irq, 1'b0);
  endtask

  task automatic t_trigger();
    trig_sel = 2'b10;
    push_rx(7);
    chk("R8", "irq at 7 with level 8", irq, 1'b0);
    chk("R3", "rx_rdy_n with 7 bytes", rx_rdy_n, 1'b0);
    push_rx(1);
    chk("R7", "irq at 8 with level 8", irq, 1'b1);
    trig_sel = 2'b11;
    settle();
    chk("R8", "irq at 8 with level 14", irq, 1'b0);
    trig_sel = 2'b00;
    settle();
    chk("R8", "irq at 8 with level 1", irq, 1'b1);
    pop_rx(8);
    pop_tx(1);
  endtask

  task automatic t_dma_rx();
    dma_mode = 1'b1;
    trig_sel = 2'b01;
    push_rx(3);
    chk("R4", "dma rx_rdy_n below level 4", rx_rdy_n, 1'b1);
    push_rx(1);
    chk("R4", "dma rx_rdy_n at level 4", rx_rdy_n, 1'b0);
    pop_rx(3);
    chk("R4", "dma rx_rdy_n held at one byte", rx_rdy_n, 1'b0);
    pop_rx(1);
    chk("R4", "dma rx_rdy_n after drain", rx_rdy_n, 1'b1);
  endtask

  task automatic t_timeout();
    push_tx(1);
    push_rx(1);
    chk("R4", "dma rx_rdy_n one byte no timeout", rx_rdy_n, 1'b1);
    rx_timeout = 1'b1; step(1); rx_timeout = 1'b0;
    settle();
    chk("R9", "dma rx_rdy_n after timeout", rx_rdy_n, 1'b0);
    chk("R7", "irq from timeout", irq, 1'b1);
    pop_rx(1);
    chk("R9", "irq after drain clears flag", irq, 1'b0);
    push_rx(1);
    chk("R9", "rx_rdy_n with flag cleared", rx_rdy_n, 1'b1);
    pop_rx(1);
    pop_tx(1);
  endtask

  task automatic t_dma_tx();
    push_tx(15);
    chk("R5", "dma tx_rdy_n at 15", tx_rdy_n, 1'b0);
    push_tx(1);
    chk("R5", "dma tx_rdy_n at 16", tx_rdy_n, 1'b1);
    push_tx(1);                      // dropped
    pop_tx(1);
    chk("R10", "tx_rdy_n after push-on-full then pop", tx_rdy_n, 1'b0);
    push_tx(1);
    tx_push = 1'b1; tx_pop = 1'b1; step(1); tx_push = 1'b0; tx_pop = 1'b0;
    settle();
    chk("R10", "tx_rdy_n after push+pop on full", tx_rdy_n, 1'b0);
    pop_rx(1);                       // pop on empty receive is dropped
    push_rx(4);
    chk("R10", "rx level after empty pop", rx_rdy_n, 1'b0);
  endtask

  task automatic t_flush();
    fifo_en = 1'b0;
    settle();
    chk("R11", "tx_rdy_n after flush", tx_rdy_n, 1'b0);
    chk("R11", "rx_rdy_n after flush", rx_rdy_n, 1'b1);
    chk("R11", "irq after flush", irq, 1'b1);
    push_rx(1);
    chk("R2", "dma ignored, one byte ready", rx_rdy_n, 1'b0);
    push_tx(1);
    chk("R6", "irq rx held tx full", irq, 1'b1);
    pop_rx(1);
    chk("R6", "irq all quiet", irq, 1'b0);
  endtask

  initial begin
    t_reset();
    t_char_mode();
    t_fifo_mode();
    t_trigger();
    t_dma_rx();
    t_timeout();
    t_dma_tx();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule